// File: doc/BRIEF.md
# External Bus Strobe Generator

This block produces the control strobes of a microcontroller's multiplexed external bus. A divide-by-four phase counter running on a fast internal clock splits each E-clock period into four quarters. From these quarters, a held bus request and a small register of pin-function enable bits, the block drives three strobe pins: a read/write line, an active-low low-byte strobe and an active-low data-bus enable.

Each strobe pin is switched on its own between its bus function and general-purpose I/O. In GPIO mode a pin drives its output bit when its direction bit is set, and is released otherwise. An access may be stretched by zero to three extra E-clock cycles for slow devices. The requester holds its request until a one-clock done pulse comes back. When an access is stretched, the data-bus enable narrows to the last quarter of the final E cycle. In special expanded mode the low-byte strobe pin also carries a tag-low input during the E-low half of each period.

Top module: `xbus_strobe_gen`

## Requirements
- R1: Reset (synchronous, `rst_n` low) clears all enable bits. The read/write pin (index 0) and the low-byte pin (index 1) then behave as GPIO in every mode, and `done` is low.
- R2: `eclk` is low for two clocks (quarters 0 and 1) and high for two clocks (quarters 2 and 3), with a period of four clocks.
- R3: A request is accepted at the clock edge that ends an E period. `done` is a one-clock pulse, visible in the first quarter after the last of `1 + stretch` E periods of the access.
- R4: With `cfg_wdata[0]` set (read/write enable), pin 0 is driven low for the whole of a write access and driven high at all other times.
- R5: With the read/write enable clear, pin 0 stays GPIO even during a write access, so no external write is signalled.
- R6: With `cfg_wdata[1]` set (low-byte enable), pin 1 is driven low during an access that is a word access or a byte access with `req_odd=1`. It is high for an even-byte access and when idle.
- R7: With the low-byte enable clear, pin 1 stays GPIO, so no low-byte write strobe is produced.
- R8: In expanded modes (`mode[1]=1`: 2 normal, 3 special) with `cfg_wdata[2]` clear, pin 2 is driven as the data-bus enable. During an unstretched read it is low in both E-high quarters, and it is high at all other times.
- R9: During a read with a non-zero stretch, the data-bus enable is low only in quarter 3 of the last E period.
- R10: The data-bus enable pin is GPIO in single-chip modes (`mode[1]=0`: 0 normal, 1 special) or when `cfg_wdata[2]` is set. Its reset value, 0, leaves the pin enabled in expanded modes.
- R11: In special expanded mode (`mode=3`) with the low-byte enable set, pin 1 carries `tag_lo` while `eclk` is low.
- R12: A GPIO-mode pin drives `gpio_out[i]` with `pin_oe[i]` equal to `gpio_dir[i]`. A pin in bus-function mode has `pin_oe[i]=1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, four times the E-clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | Operating mode: bit1 expanded, bit0 special |
| cfg_we | input | 1 | Load enable for the pin-function register |
| cfg_wdata | input | 3 | Bit0 read/write enable, bit1 low-byte enable, bit2 data-bus-enable off |
| req | input | 1 | Bus access request, held until done |
| req_write | input | 1 | Access is a write |
| req_word | input | 1 | Access is a word access |
| req_odd | input | 1 | Byte access to an odd address |
| req_stretch | input | STRETCH_W | Extra E cycles added to the access |
| tag_lo | input | 1 | Tag-low value shared onto pin 1 in special expanded mode |
| gpio_out | input | 3 | GPIO output values per pin |
| gpio_dir | input | 3 | GPIO direction per pin (1 = drive) |
| eclk | output | 1 | E clock |
| done | output | 1 | One-clock access completion pulse |
| pin_out | output | 3 | Pin output values: 0 read/write, 1 low-byte strobe, 2 data-bus enable |
| pin_oe | output | 3 | Pin output enables |

## Verification
The bench goes after the stretched read. A design that keeps the E-high enable window there would show two low quarters instead of one, and one that drops it would show none. It runs write accesses with the read/write and low-byte functions disabled: a design that still drove the function onto the pin would show an enabled output. It checks the exact clock in which done appears for each stretch value, which an off-by-one E-cycle counter misses. It also checks the tag-low sharing and the GPIO fallback in single-chip mode, where a design that drove the data-bus enable regardless of mode would be caught.

// File: rtl/xbs_pkg.sv
// Shared types for the external bus strobe generator.
package xbs_pkg;
    localparam int NPIN   = 3;
    localparam int PIN_RW = 0;
    localparam int PIN_LB = 1;
    localparam int PIN_DE = 2;

    typedef enum logic [1:0] {
        MODE_SC_NORM  = 2'd0,
        MODE_SC_SPEC  = 2'd1,
        MODE_EXP_NORM = 2'd2,
        MODE_EXP_SPEC = 2'd3
    } xbs_mode_e;

    typedef struct packed {
        logic write;
        logic word;
        logic odd;
    } xbs_attr_t;
endpackage

// File: rtl/xbs_phase.sv
// Quarter-phase generator: a divide-by-four counter on the fast clock.
// Assumes the E clock is high during quarters 2 and 3.
module xbs_phase (
    input  logic       clk,
    input  logic       rst_n,
    output logic [1:0] qph,
    output logic       eclk,
    output logic       last_q
);
    // Advance the quarter counter every fast clock.
    always_ff @(posedge clk) begin
        if (!rst_n) qph <= 2'd0;
        else        qph <= qph + 2'd1;
    end

    // Derive E clock and end-of-period flag.
    always_comb begin
        eclk   = qph[1];
        last_q = (qph == 2'd3);
    end
endmodule

// File: rtl/xbs_seq.sv
// Access sequencer: accepts a held request at the end of an E period,
// counts 1+stretch E periods, then pulses done for one fast clock.
// Assumes the requester drops req on seeing done.
module xbs_seq import xbs_pkg::*; #(
    parameter int STRETCH_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 last_q,
    input  logic                 req,
    input  xbs_attr_t            attr,
    input  logic [STRETCH_W-1:0] stretch,
    output logic                 busy,
    output xbs_attr_t            attr_q,
    output logic                 stretched,
    output logic                 remain_zero,
    output logic                 done
);
    logic [STRETCH_W-1:0] remain;

    // Track the access through its E periods and issue completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            remain    <= '0;
            attr_q    <= '0;
            stretched <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            if (last_q) begin
                if (busy) begin
                    if (remain == '0) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        remain <= remain - 1'b1;
                    end
                end else if (req) begin
                    busy      <= 1'b1;
                    remain    <= stretch;
                    stretched <= (stretch != '0);
                    attr_q    <= attr;
                end
            end
        end
    end

    // Flag the final E period of the access.
    always_comb remain_zero = (remain == '0);
endmodule

// File: rtl/xbs_pinmux.sv
// One pin's selector between its bus function and general-purpose I/O.
// Assumes func_sel is stable within a clock.
module xbs_pinmux (
    input  logic func_sel,
    input  logic func_val,
    input  logic gpio_val,
    input  logic gpio_dir,
    output logic pin_val,
    output logic pin_drv
);
    // Choose the pin source and its drive enable.
    always_comb begin
        pin_val = func_sel ? func_val : gpio_val;
        pin_drv = func_sel ? 1'b1     : gpio_dir;
    end
endmodule

// File: rtl/xbus_strobe_gen.sv
// External bus strobe generator top. Builds read/write, low-byte strobe
// and data-bus enable from the quarter phase, the access sequencer and
// the pin-function register, and routes each through its own pin mux.
// Assumes one access in flight, with the request held until done.
module xbus_strobe_gen import xbs_pkg::*; #(
    parameter int STRETCH_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           mode,
    input  logic                 cfg_we,
    input  logic [2:0]           cfg_wdata,
    input  logic                 req,
    input  logic                 req_write,
    input  logic                 req_word,
    input  logic                 req_odd,
    input  logic [STRETCH_W-1:0] req_stretch,
    input  logic                 tag_lo,
    input  logic [2:0]           gpio_out,
    input  logic [2:0]           gpio_dir,
    output logic                 eclk,
    output logic                 done,
    output logic [2:0]           pin_out,
    output logic [2:0]           pin_oe
);
    logic [2:0]  en_q;
    logic [1:0]  qph;
    logic        last_q;
    logic        busy, stretched, remain_zero, de_act;
    xbs_attr_t   attr_in, attr_q;
    logic [NPIN-1:0] func_sel, func_val;

    // Hold the pin-function enable bits.
    always_ff @(posedge clk) begin
        if (!rst_n)      en_q <= 3'b000;
        else if (cfg_we) en_q <= cfg_wdata;
    end

    xbs_phase u_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .qph    (qph),
        .eclk   (eclk),
        .last_q (last_q)
    );

    // Pack the request attributes for the sequencer.
    always_comb attr_in = '{write: req_write, word: req_word, odd: req_odd};

    xbs_seq #(.STRETCH_W(STRETCH_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .last_q      (last_q),
        .req         (req),
        .attr        (attr_in),
        .stretch     (req_stretch),
        .busy        (busy),
        .attr_q      (attr_q),
        .stretched   (stretched),
        .remain_zero (remain_zero),
        .done        (done)
    );

    // Data-bus enable window: E-high of reads, last quarter if stretched.
    always_comb de_act = busy && !attr_q.write && eclk &&
                         (!stretched || (remain_zero && last_q));

    // Bus-function selection and values for each strobe pin.
    always_comb begin
        func_sel[PIN_RW] = en_q[0];
        func_val[PIN_RW] = !(busy && attr_q.write);
        func_sel[PIN_LB] = en_q[1];
        if (mode == MODE_EXP_SPEC && !eclk)
            func_val[PIN_LB] = tag_lo;
        else
            func_val[PIN_LB] = !(busy && (attr_q.word || attr_q.odd));
        func_sel[PIN_DE] = mode[1] && !en_q[2];
        func_val[PIN_DE] = !de_act;
    end

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        xbs_pinmux u_mux (
            .func_sel (func_sel[i]),
            .func_val (func_val[i]),
            .gpio_val (gpio_out[i]),
            .gpio_dir (gpio_dir[i]),
            .pin_val  (pin_out[i]),
            .pin_drv  (pin_oe[i])
        );
    end
endmodule

// File: rtl/xbs_strobe_chk.sv
// Assertion checker for the strobe generator, bound to the top module.
// Assumes it observes ports plus the enable register.
module xbs_strobe_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode,
    input logic [2:0] en_q,
    input logic       eclk,
    input logic       done,
    input logic [2:0] pin_out,
    input logic [2:0] pin_oe,
    input logic [2:0] gpio_dir
);
    a_r2_eclk_high_two: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eclk) |=> eclk);
    a_r2_eclk_low_two: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(eclk) |=> !eclk);
    a_r3_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r3_done_at_e_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (!eclk && $past(eclk)));
    a_r8_de_low_in_e_high: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe[2] && !pin_out[2]) |-> eclk);
    a_r10_de_gpio_single_chip: assert property (@(posedge clk) disable iff (!rst_n)
        !mode[1] |-> (pin_oe[2] == gpio_dir[2]));
    a_r5_rw_gpio_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q[0] |-> (pin_oe[0] == gpio_dir[0]));
    a_r7_lb_gpio_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q[1] |-> (pin_oe[1] == gpio_dir[1]));
endmodule

bind xbus_strobe_gen xbs_strobe_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .en_q     (en_q),
    .eclk     (eclk),
    .done     (done),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe),
    .gpio_dir (gpio_dir)
);

// File: tb/tb_xbus_strobe_gen.sv
module tb_xbus_strobe_gen;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 9;
    // {write, word, odd, stretch[2], cfg[3], mode[2], rw_oe, rw, lb_oe, lb, pad, de_lows[2]}
    localparam logic [16:0] VEC [NVEC] = '{
        {1'b0,1'b0,1'b0,2'd0,3'b011,2'd2,1'b1,1'b1,1'b1,1'b1,1'b0,2'd2},
        {1'b1,1'b0,1'b1,2'd0,3'b011,2'd2,1'b1,1'b0,1'b1,1'b0,1'b0,2'd0},
        {1'b0,1'b1,1'b0,2'd1,3'b011,2'd2,1'b1,1'b1,1'b1,1'b0,1'b0,2'd1},
        {1'b1,1'b1,1'b0,2'd3,3'b011,2'd2,1'b1,1'b0,1'b1,1'b0,1'b0,2'd0},
        {1'b1,1'b0,1'b1,2'd0,3'b000,2'd2,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0},
        {1'b0,1'b0,1'b0,2'd2,3'b111,2'd2,1'b1,1'b1,1'b1,1'b1,1'b0,2'd0},
        {1'b0,1'b0,1'b1,2'd0,3'b011,2'd0,1'b1,1'b1,1'b1,1'b0,1'b0,2'd0},
        {1'b1,1'b0,1'b0,2'd1,3'b001,2'd2,1'b1,1'b0,1'b0,1'b0,1'b0,2'd0},
        {1'b0,1'b0,1'b0,2'd3,3'b011,2'd2,1'b1,1'b1,1'b1,1'b1,1'b0,2'd1}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic [1:0] mode = 2'd2;
    logic cfg_we = 1'b0;
    logic [2:0] cfg_wdata = 3'b000;
    logic req = 1'b0, req_write = 1'b0, req_word = 1'b0, req_odd = 1'b0;
    logic [1:0] req_stretch = 2'd0;
    logic tag_lo = 1'b1;
    logic [2:0] gpio_out = 3'b000, gpio_dir = 3'b000;
    logic eclk, done;
    logic [2:0] pin_out, pin_oe;
    int n_chk = 0, n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xbus_strobe_gen dut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .req(req), .req_write(req_write), .req_word(req_word), .req_odd(req_odd),
        .req_stretch(req_stretch), .tag_lo(tag_lo), .gpio_out(gpio_out),
        .gpio_dir(gpio_dir), .eclk(eclk), .done(done), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic load_cfg(input logic [2:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Reach a negedge that lies in quarter 0.
    task automatic sync_q0();
        while (eclk !== 1'b1) @(negedge clk);
        while (eclk !== 1'b0) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state
        gpio_dir = 3'b101; gpio_out = 3'b010;
        repeat (2) @(negedge clk);
        chk("R1 rw/lb oe", int'(pin_oe[1:0]), 1);
        chk("R1 rw gpio val", int'(pin_out[0]), 0);
        chk("R1 done low", int'(done), 0);
        chk("R10 de enabled out of reset in expanded, idle high", int'({pin_oe[2], pin_out[2]}), 3);
        rst_n = 1'b1;
        // R2: eclk pattern after release
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            chk("R2 eclk", int'(eclk), ((k % 4) == 1 || (k % 4) == 2) ? 1 : 0);
        end
        gpio_dir = 3'b000;

        // Vector table: R3-R10
        for (int v = 0; v < NVEC; v++) begin
            int lows, s;
            logic [16:0] e;
            e = VEC[v];
            mode = e[8:7];
            load_cfg(e[11:9]);
            s = int'(e[13:12]);
            req_write = e[16]; req_word = e[15]; req_odd = e[14]; req_stretch = e[13:12];
            sync_q0();
            req = 1'b1;
            lows = 0;
            for (int k = 1; k <= 4 + 4*(s+1); k++) begin
                @(negedge clk);
                if (pin_oe[2] && !pin_out[2]) lows++;
                if (k == 4) begin
                    chk($sformatf("R4/R5 v%0d rw oe", v), int'(pin_oe[0]), int'(e[6]));
                    if (e[6]) chk($sformatf("R4 v%0d rw level", v), int'(pin_out[0]), int'(e[5]));
                    chk($sformatf("R6/R7 v%0d lb oe", v), int'(pin_oe[1]), int'(e[4]));
                    if (e[4]) chk($sformatf("R6 v%0d lb level", v), int'(pin_out[1]), int'(e[3]));
                end
                if (k == 3 + 4*(s+1)) chk($sformatf("R3 v%0d done early", v), int'(done), 0);
            end
            chk($sformatf("R3 v%0d done", v), int'(done), 1);
            req = 1'b0;
            chk($sformatf("R8/R9/R10 v%0d de low quarters", v), lows, int'(e[1:0]));
            @(negedge clk);
            chk($sformatf("R3 v%0d done pulse width", v), int'(done), 0);
            if (e[6]) chk($sformatf("R4 v%0d rw idle high", v), int'(pin_out[0]), 1);
        end

        // R11: tag-low sharing in special expanded mode
        mode = 2'd3; tag_lo = 1'b0;
        load_cfg(3'b011);
        sync_q0();
        chk("R11 lb carries tag_lo in E low", int'(pin_out[1]), 0);
        @(negedge clk); @(negedge clk);
        chk("R11 lb idle high in E high", int'(pin_out[1]), 1);

        // R12: GPIO fallback in single-chip mode
        mode = 2'd0; gpio_dir = 3'b111; gpio_out = 3'b101;
        load_cfg(3'b000);
        chk("R12 gpio oe", int'(pin_oe), 7);
        chk("R12 gpio val", int'(pin_out), 5);
        gpio_dir = 3'b000;
        @(negedge clk);
        chk("R12 gpio released", int'(pin_oe), 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule